// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Early Warning

This block is a watchdog counter on a plain 32-bit register bus (byte address, write strobe, write data, combinational read data). Software loads a 32-bit tick count, sets an optional early-warning level and enables the counter. Once enabled, the counter drops by one on every clock. If software does not reload it in time, it reaches zero and raises the expiry interrupt. An earlier warning interrupt can be raised when the count passes a chosen level.

Stray writes cannot disturb the count, the warning level or the enable. Each write to one of those three registers only takes effect if the write just before it put a fixed 32-bit key into the unlock register. Both interrupt conditions are held in sticky status bits. Software reads them back and clears them through a write-one-to-clear register, which needs no key. The interrupt lines are level outputs that follow the status bits.

Top module: `guard_timer`

## Requirements
- R1: After reset the count reads 0xFFFFFFFF, the warning level reads 0, the enable reads 0, the status reads 0, both interrupt lines are low and no key is armed.
- R2: Writing 0xF1D0DEAD to the unlock register (offset 0x0C) arms the next write. An armed write to the count (0x00), the warning level (0x04) or the enable (0x08, bit 0) takes effect.
- R3: A write to 0x00, 0x04 or 0x08 that is not armed leaves that register unchanged. This covers a write with no key before it and a write after a wrong key value.
- R4: Any register write after the key consumes the arm, whether or not it reaches a protected register. A write of the key itself arms again.
- R5: While the enable is 1, the count falls by one per clock. Counting starts on the clock after the enable write. Writing 0 to the enable holds the present count.
- R6: Reading 0x00 returns the remaining ticks over the full 32 bits. An armed count write reloads it, and this takes priority over the decrement in the same cycle (keepalive).
- R7: Status bit 8 (warning) sets on the clock edge where an enabled counter decrements to a value equal to a nonzero warning level. A warning level of 0 never sets it.
- R8: Status bit 9 (expiry) sets on the clock edge where an enabled counter decrements from 1 to 0. The count then stays at 0 until it is reloaded.
- R9: The status bits read at offset 0x10. Writing 1s to bits 8 or 9 at 0x10 clears those bits without a key. Reads of 0x0C return 0.
- R10: `irq_warn` equals status bit 8 and `irq_expire` equals status bit 9 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count tick per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_warn | output | 1 | Early-warning interrupt level |
| irq_expire | output | 1 | Expiry interrupt level |

## Verification
The bound checker tests several rules on every cycle. It checks the per-cycle decrement and the hold while disabled. It checks that an unarmed warning-level write leaves the register alone, and that any write other than the key leaves the unit disarmed. It checks that the expiry and warning bits rise on the edge their condition is met. The bench scenarios cover the remaining behaviour: the reset image, reload priority during a live countdown, the effect of a zero warning level, the count holding at zero, and selective clearing of the status bits.

// File: rtl/gt_pkg.sv
package gt_pkg;
    localparam int OFS_COUNT  = 'h00;
    localparam int OFS_WARN   = 'h04;
    localparam int OFS_ENABLE = 'h08;
    localparam int OFS_UNLOCK = 'h0C;
    localparam int OFS_CLEAR  = 'h10;

    localparam logic [31:0] UNLOCK_KEY = 32'hF1D0_DEAD;

    localparam int WARN_BIT   = 8;
    localparam int EXPIRE_BIT = 9;
endpackage

// File: rtl/gt_count.sv
module gt_count #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] warn_lvl,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] ticks,
    output logic              hit_warn,
    output logic              hit_zero
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] ticks_d, ticks_q;
    logic              step;

    always_comb begin
        step     = run && !load && (ticks_q != '0);
        ticks_d  = ticks_q;
        if (load) begin
            ticks_d = load_val;
        end else if (step) begin
            ticks_d = ticks_q - ONE;
        end
        hit_warn = step && (warn_lvl != '0) && ((ticks_q - ONE) == warn_lvl);
        hit_zero = step && (ticks_q == ONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_q <= '1;
        end else begin
            ticks_q <= ticks_d;
        end
    end

    assign ticks = ticks_q;
endmodule

// File: rtl/gt_regs.sv
module gt_regs
    import gt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] ticks,
    input  logic              hit_warn,
    input  logic              hit_zero,
    output logic              load,
    output logic [DATA_W-1:0] warn_lvl,
    output logic              run,
    output logic              armed,
    output logic              st_warn,
    output logic              st_expire
);
    typedef struct packed {
        logic              armed;
        logic              run;
        logic [DATA_W-1:0] warn;
        logic              st_warn;
        logic              st_expire;
    } regs_t;

    regs_t s_d, s_q;

    logic sel_count, sel_warn, sel_enable, sel_unlock, sel_clear;
    logic granted;

    always_comb begin
        sel_count  = (bus_addr == ADDR_W'(OFS_COUNT));
        sel_warn   = (bus_addr == ADDR_W'(OFS_WARN));
        sel_enable = (bus_addr == ADDR_W'(OFS_ENABLE));
        sel_unlock = (bus_addr == ADDR_W'(OFS_UNLOCK));
        sel_clear  = (bus_addr == ADDR_W'(OFS_CLEAR));
        granted    = bus_we && s_q.armed;

        s_d  = s_q;
        load = granted && sel_count;

        if (bus_we) begin
            s_d.armed = sel_unlock && (bus_wdata == DATA_W'(UNLOCK_KEY));
        end
        if (granted && sel_warn) begin
            s_d.warn = bus_wdata;
        end
        if (granted && sel_enable) begin
            s_d.run = bus_wdata[0];
        end
        if (bus_we && sel_clear) begin
            if (bus_wdata[WARN_BIT])   s_d.st_warn   = 1'b0;
            if (bus_wdata[EXPIRE_BIT]) s_d.st_expire = 1'b0;
        end
        if (hit_warn) s_d.st_warn   = 1'b1;
        if (hit_zero) s_d.st_expire = 1'b1;

        bus_rdata = '0;
        if (sel_count)  bus_rdata = ticks;
        if (sel_warn)   bus_rdata = s_q.warn;
        if (sel_enable) bus_rdata[0] = s_q.run;
        if (sel_clear) begin
            bus_rdata[WARN_BIT]   = s_q.st_warn;
            bus_rdata[EXPIRE_BIT] = s_q.st_expire;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign warn_lvl  = s_q.warn;
    assign run       = s_q.run;
    assign armed     = s_q.armed;
    assign st_warn   = s_q.st_warn;
    assign st_expire = s_q.st_expire;
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_warn,
    output logic              irq_expire
);
    logic [DATA_W-1:0] ticks_w;
    logic [DATA_W-1:0] warn_w;
    logic              run_w, load_w, armed_w;
    logic              hit_warn_w, hit_zero_w;

    gt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ticks     (ticks_w),
        .hit_warn  (hit_warn_w),
        .hit_zero  (hit_zero_w),
        .load      (load_w),
        .warn_lvl  (warn_w),
        .run       (run_w),
        .armed     (armed_w),
        .st_warn   (irq_warn),
        .st_expire (irq_expire)
    );

    gt_count #(.DATA_W(DATA_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .warn_lvl (warn_w),
        .load     (load_w),
        .load_val (bus_wdata),
        .ticks    (ticks_w),
        .hit_warn (hit_warn_w),
        .hit_zero (hit_zero_w)
    );
endmodule

// File: rtl/gt_checker.sv
module gt_checker
    import gt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] ticks,
    input logic [DATA_W-1:0] warn_lvl,
    input logic              run,
    input logic              load,
    input logic              armed,
    input logic              irq_warn,
    input logic              irq_expire
);
    // R5
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !load && (ticks != '0) |=> ticks == $past(ticks) - DATA_W'(1));

    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load |=> $stable(ticks));

    // R3
    unarmed_warn_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !armed && (bus_addr == ADDR_W'(OFS_WARN)) |=> $stable(warn_lvl));

    // R4
    arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !((bus_addr == ADDR_W'(OFS_UNLOCK)) && (bus_wdata == DATA_W'(UNLOCK_KEY)))
        |=> !armed);

    // R8
    expire_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !load && (ticks == DATA_W'(1)) |=> irq_expire && (ticks == '0));

    // R7
    warn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !load && (warn_lvl != '0) && (ticks == warn_lvl + DATA_W'(1)) |=> irq_warn);
endmodule

bind guard_timer gt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_gt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .ticks      (ticks_w),
    .warn_lvl   (warn_w),
    .run        (run_w),
    .load       (load_w),
    .armed      (armed_w),
    .irq_warn   (irq_warn),
    .irq_expire (irq_expire)
);

// File: tb/test_guard_timer.sv
module test_guard_timer;
    localparam logic [31:0] KEY = 32'hF1D0_DEAD;
    localparam logic [7:0] A_CNT = 8'h00, A_WRN = 8'h04, A_EN = 8'h08,
                           A_KEY = 8'h0C, A_CLR = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_warn, irq_expire;
    int          checks = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    guard_timer i_guard_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_warn(irq_warn), .irq_expire(irq_expire)
    );

    // prefix: 0 none, 1 correct key, 2 wrong key
    typedef struct packed {
        logic [1:0]  prefix;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  raddr;
        logic [31:0] expect_v;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd1, 8'h00, 32'd100,        8'h00, 32'd100},        // R2 count
        '{2'd0, 8'h00, 32'd55,         8'h00, 32'd100},        // R3 no key
        '{2'd1, 8'h04, 32'd7,          8'h04, 32'd7},          // R2 warn
        '{2'd2, 8'h04, 32'd9,          8'h04, 32'd7},          // R3 wrong key
        '{2'd1, 8'h08, 32'd2,          8'h08, 32'd0},          // R2 bit0 only
        '{2'd1, 8'h00, 32'hFFFF_FFFF,  8'h00, 32'hFFFF_FFFF},  // R6 full width
        '{2'd0, 8'h0C, 32'h0000_0001,  8'h0C, 32'd0}           // R9 unlock reads 0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic kwr(input logic [7:0] a, input logic [31:0] d);
        wr(A_KEY, KEY);
        wr(a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(A_CNT, v); check("R1 count", v, 32'hFFFF_FFFF);
        rd(A_WRN, v); check("R1 warn", v, 32'd0);
        rd(A_EN, v);  check("R1 enable", v, 32'd0);
        rd(A_CLR, v); check("R1 status", v, 32'd0);
        check("R1 irqs", {30'd0, irq_warn, irq_expire}, 32'd0);
        wr(A_CNT, 32'd3);
        rd(A_CNT, v); check("R1 disarmed", v, 32'hFFFF_FFFF);

        for (int i = 0; i < 7; i++) begin
            if (VECS[i].prefix == 2'd1) wr(A_KEY, KEY);
            if (VECS[i].prefix == 2'd2) wr(A_KEY, 32'hDEAD_BEEF);
            wr(VECS[i].addr, VECS[i].data);
            rd(VECS[i].raddr, v);
            check($sformatf("R2/R3 table row %0d", i), v, VECS[i].expect_v);
        end

        // R4: a clear write consumes the arm
        wr(A_KEY, KEY); wr(A_CLR, 32'd0); wr(A_CNT, 32'd5);
        rd(A_CNT, v); check("R4 arm consumed", v, 32'hFFFF_FFFF);
        // R4: key twice still armed
        wr(A_KEY, KEY); kwr(A_WRN, 32'd3);
        rd(A_WRN, v); check("R4 rearm", v, 32'd3);

        // R5 R7 R8 countdown
        kwr(A_CNT, 32'd10);
        kwr(A_WRN, 32'd4);
        kwr(A_EN, 32'd1);
        tick(5);
        rd(A_CNT, v); check("R5 decrement", v, 32'd5);
        check("R7 not yet", {31'd0, irq_warn}, 32'd0);
        tick(1);
        rd(A_CNT, v); check("R7 count at level", v, 32'd4);
        rd(A_CLR, v); check("R7 warn status", v, 32'h100);
        check("R10 irq_warn", {31'd0, irq_warn}, 32'd1);
        tick(4);
        rd(A_CLR, v); check("R8 expire status", v, 32'h300);
        check("R10 irq_expire", {31'd0, irq_expire}, 32'd1);
        tick(3);
        rd(A_CNT, v); check("R8 stays zero", v, 32'd0);

        // R9 selective clear without key
        wr(A_CLR, 32'h200);
        rd(A_CLR, v); check("R9 clear expire", v, 32'h100);
        check("R10 lines after clear", {30'd0, irq_warn, irq_expire}, 32'd2);
        wr(A_CLR, 32'h100);
        rd(A_CLR, v); check("R9 clear warn", v, 32'd0);

        // R5 R6 hold and keepalive (still enabled)
        kwr(A_CNT, 32'd20);
        rd(A_CNT, v); check("R6 reload", v, 32'd20);
        tick(3);
        kwr(A_EN, 32'd0);
        tick(4);
        rd(A_CNT, v); check("R5 hold", v, 32'd15);
        kwr(A_EN, 32'd1);
        tick(2);
        rd(A_CNT, v); check("R5 resume", v, 32'd13);
        kwr(A_CNT, 32'd20);
        tick(10);
        rd(A_CNT, v); check("R6 keepalive count", v, 32'd10);
        rd(A_CLR, v); check("R6 keepalive no status", v, 32'd0);

        // R7 zero level disables warning
        kwr(A_WRN, 32'd0);
        tick(8);
        rd(A_CNT, v); check("R8 reached zero", v, 32'd0);
        rd(A_CLR, v); check("R7 zero level", v, 32'h200);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule